// File: doc/BRIEF.md
# Two-Bit Condition Code Arithmetic Unit

This block is an integer adder/subtractor whose flag state is a single two-bit condition code. The code has no fixed meaning. A signed operation writes one of four outcomes: zero, negative, positive, or overflow. An unsigned operation writes the four combinations of carry-out and a zero result. Because the same code value means different things in the two classes, signed and unsigned arithmetic are separate operations. A compare operation writes the code the way a signed subtract does and leaves the result alone.

A consuming instruction, such as a branch or a conditional move, supplies a four-bit mask with one bit for each code value. The take output is high when the mask bit for the current registered code is set. A single test can therefore accept any subset of the four outcomes. The code changes only on cycles where the set-code enable is high.

Top module: `cc_unit`

## Requirements
- R1: A synchronous active-high reset clears the registered result and the condition code to 0.
- R2: The operation select is encoded as 0 = signed add, 1 = signed subtract, 2 = unsigned add, 3 = unsigned subtract, 4 = compare. Adds register a+b and subtracts register a-b, both modulo 2^W, on the clock edge after the operands are presented.
- R3: After a signed add or subtract with set-code high, the code reads 3 on overflow. Otherwise it reads 0 for a zero result, 1 for a negative result and 2 for a positive result. Overflow wins over the zero and sign tests.
- R4: After an unsigned add or subtract with set-code high, the code bit 1 holds the carry-out and bit 0 is set when the result is nonzero. For a subtract, a carry-out means there was no borrow (a >= b).
- R5: With set-code low, the condition code keeps its value, while an arithmetic operation still updates the result.
- R6: A compare with set-code high writes the code exactly as a signed subtract of the same operands would, and the registered result keeps its previous value.
- R7: take_o equals mask bit (3 - code), so mask bit 3 tests code 0 and mask bit 0 tests code 3. Mask 4'b1111 always takes and mask 4'b0000 never takes. take_o follows the mask in the same cycle and the code as registered.
- R8: Operation select values 5 to 7 change neither the result nor the condition code, even with set-code high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation select (see R2) |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| set_cc_i | input | 1 | Write the condition code this cycle |
| mask_i | input | 4 | Condition test mask of the consuming instruction |
| result_o | output | W | Registered arithmetic result |
| cc_o | output | 2 | Registered condition code |
| take_o | output | 1 | Condition test outcome for branch or select |

## Verification
A wrong code value is visible on cc_o one edge after the operation that wrote it. It also reaches take_o in that same cycle, because the mask test reads the registered code directly. A corrupted result register shows up at result_o one edge after the operation. A compare that wrongly writes the result, or an illegal operation that leaks a write, is caught on the next sample through a result or code that differs from the value held before. The test sweeps every single-hot mask over fixed codes, so a swapped mask bit order produces a wrong take_o within one cycle.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int CC_W   = 2;
  localparam int MASK_W = 1 << CC_W;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SADD = 3'd0,
    OP_SSUB = 3'd1,
    OP_UADD = 3'd2,
    OP_USUB = 3'd3,
    OP_CMP  = 3'd4
  } cc_op_e;
endpackage

// File: rtl/cc_addsub.sv
module cc_addsub
  import cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    sum,
  output logic [CC_W-1:0] code,
  output logic            legal,
  output logic            wr_res
);
  logic          is_sub, is_signed, carry, ovf, zero;
  logic [W-1:0]  b_eff;

  always_comb begin
    is_sub    = (op == OP_SSUB) || (op == OP_USUB) || (op == OP_CMP);
    is_signed = (op == OP_SADD) || (op == OP_SSUB) || (op == OP_CMP);
    legal     = (op <= OP_CMP);
    wr_res    = legal && (op != OP_CMP);
    b_eff     = is_sub ? ~b : b;
    {carry, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    ovf       = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    zero      = (sum == '0);
    if (is_signed) begin
      if (ovf)              code = 2'd3;
      else if (zero)        code = 2'd0;
      else if (sum[W-1])    code = 2'd1;
      else                  code = 2'd2;
    end else begin
      code = {carry, ~zero};
    end
  end
endmodule

// File: rtl/cc_reg.sv
module cc_reg
  import cc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CC_W-1:0] d,
  output logic [CC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cc_test.sv
module cc_test
  import cc_pkg::*;
(
  input  logic [CC_W-1:0]   code,
  input  logic [MASK_W-1:0] mask,
  output logic              take
);
  logic [MASK_W-1:0] hit;

  for (genvar i = 0; i < MASK_W; i++) begin : g_hit
    assign hit[i] = mask[MASK_W-1-i] && (code == CC_W'(i));
  end

  assign take = |hit;
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              set_cc_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [W-1:0]      result_o,
  output logic [CC_W-1:0]   cc_o,
  output logic              take_o
);
  logic [W-1:0]    sum;
  logic [CC_W-1:0] code_next;
  logic            legal, wr_res;

  cc_addsub #(.W(W)) u_arith (
    .op(op_i), .a(a_i), .b(b_i),
    .sum(sum), .code(code_next), .legal(legal), .wr_res(wr_res)
  );

  cc_reg u_code (
    .clk(clk), .rst(rst), .load(legal && set_cc_i),
    .d(code_next), .q(cc_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         result_o <= '0;
    else if (wr_res) result_o <= sum;
  end

  cc_test u_test (.code(cc_o), .mask(mask_i), .take(take_o));
endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk
  import cc_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic              set_cc_i,
  input logic [MASK_W-1:0] mask_i,
  input logic [W-1:0]      result_o,
  input logic [CC_W-1:0]   cc_o,
  input logic              take_o
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cc_o == '0) && (result_o == '0));

  a_r5_code_held: assert property (@(posedge clk) disable iff (rst)
    !set_cc_i |=> $stable(cc_o));

  a_r6_cmp_keeps_result: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP) |=> $stable(result_o));

  a_r8_illegal_no_effect: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_CMP) |=> $stable(result_o) && $stable(cc_o));

  a_r4_unsigned_zero_bit: assert property (@(posedge clk) disable iff (rst)
    (set_cc_i && (op_i == OP_UADD || op_i == OP_USUB)) |=> (cc_o[0] == (result_o != '0)));

  a_r3_signed_zero_code: assert property (@(posedge clk) disable iff (rst)
    (set_cc_i && (op_i == OP_SADD || op_i == OP_SSUB)) |=> (cc_o != 2'd0 || result_o == '0));

  a_r7_all_ones_takes: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '1) |-> take_o);

  a_r7_zero_never_takes: assert property (@(posedge clk) disable iff (rst)
    (mask_i == '0) |-> !take_o);

  wire unused_ok = ^{a_i, b_i};
endmodule

bind cc_unit cc_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cc_unit.sv
module sim_cc_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = 3'd7;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic         set_cc_i = 1'b0;
  logic [3:0]   mask_i = 4'b0000;
  logic [W-1:0] result_o;
  logic [1:0]   cc_o;
  logic         take_o;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] res;
    logic [1:0]   cc;
    logic [3:0]   mask;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] m_res = '0;
  logic [1:0]   m_cc  = '0;

  always #5 clk = ~clk;

  cc_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .set_cc_i(set_cc_i), .mask_i(mask_i),
    .result_o(result_o), .cc_o(cc_o), .take_o(take_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation and records the expected outcome.
  task automatic drive(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sc, input logic [3:0] m, input string tag);
    longint sa, sb64, r64;
    logic [W-1:0] r;
    logic sub, carry, ovf;
    logic [1:0] code;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; set_cc_i = sc; mask_i = m;
    sub = (op == 3'd1) || (op == 3'd3) || (op == 3'd4);
    sa = longint'($signed(a)); sb64 = longint'($signed(b));
    r64 = sub ? sa - sb64 : sa + sb64;
    r = r64[W-1:0];
    ovf = (r64 > 64'sd2147483647) || (r64 < -64'sd2147483648);
    if (op == 3'd2 || op == 3'd3) begin
      carry = sub ? (a >= b) : ((64'(a) + 64'(b)) > 64'hFFFF_FFFF);
      code = {carry, r != '0};
    end else begin
      code = ovf ? 2'd3 : (r == '0) ? 2'd0 : r[W-1] ? 2'd1 : 2'd2;
    end
    if (op <= 3'd3) m_res = r;
    if (op <= 3'd4 && sc) m_cc = code;
    sb.push_back('{m_res, m_cc, m, tag});
  endtask

  // Monitor: compares outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " result"}, result_o, e.res);
        check({e.tag, " code"}, W'(cc_o), W'(e.cc));
        check({e.tag, " take"}, W'(take_o), W'(e.mask[3 - e.cc]));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    mask_i = 4'b1000;
    #1;
    check("R1 reset result", result_o, '0);
    check("R1 reset code", W'(cc_o), '0);
    check("R7 reset take code0", W'(take_o), 1);
    @(negedge clk); rst = 1'b0;

    // R3 signed encodings
    drive(3'd0, 32'd5, -32'sd5, 1, 4'b1000, "R3 sadd zero");
    drive(3'd0, 32'd3, -32'sd10, 1, 4'b0100, "R3 sadd negative");
    drive(3'd0, 32'd7, 32'd8, 1, 4'b0010, "R3 sadd positive");
    drive(3'd0, 32'h7FFF_FFFF, 32'd1, 1, 4'b0001, "R3 sadd overflow");
    drive(3'd1, 32'h8000_0000, 32'd1, 1, 4'b0001, "R3 ssub overflow");
    drive(3'd0, 32'h8000_0000, 32'h8000_0000, 1, 4'b1000, "R3 overflow over zero");
    drive(3'd1, 32'd20, 32'd30, 1, 4'b0100, "R2 ssub negative");
    // R4 unsigned encodings
    drive(3'd2, 32'd0, 32'd0, 1, 4'b1000, "R4 uadd zero nocarry");
    drive(3'd2, 32'd1, 32'd2, 1, 4'b0100, "R4 uadd nonzero nocarry");
    drive(3'd2, 32'hFFFF_FFFF, 32'd1, 1, 4'b0010, "R4 uadd zero carry");
    drive(3'd2, 32'hFFFF_FFFF, 32'd2, 1, 4'b0001, "R4 uadd nonzero carry");
    drive(3'd3, 32'd5, 32'd5, 1, 4'b0010, "R4 usub equal noborrow");
    drive(3'd3, 32'd3, 32'd5, 1, 4'b0100, "R4 usub borrow");
    drive(3'd3, 32'd9, 32'd4, 1, 4'b0001, "R4 usub noborrow");
    // R5 code held while result moves
    drive(3'd0, 32'd100, 32'd23, 0, 4'b1111, "R5 sadd no set");
    drive(3'd3, 32'd1, 32'd2, 0, 4'b0000, "R5 usub no set");
    // R6 compare
    drive(3'd4, 32'd4, 32'd9, 1, 4'b0100, "R6 cmp less");
    drive(3'd4, 32'd9, 32'd9, 1, 4'b1000, "R6 cmp equal");
    drive(3'd4, 32'h8000_0000, 32'd1, 1, 4'b0001, "R6 cmp overflow");
    drive(3'd4, 32'd50, 32'd1, 1, 4'b0010, "R6 cmp greater");
    // R8 illegal selects
    drive(3'd5, 32'd1, 32'd1, 1, 4'b0010, "R8 op5");
    drive(3'd6, 32'hFFFF_FFFF, 32'd1, 1, 4'b0010, "R8 op6");
    drive(3'd7, 32'd0, 32'd0, 1, 4'b0010, "R8 op7");
    // R7 mask sweep over each code value
    for (int c = 0; c < 4; c++) begin
      case (c)
        0: drive(3'd0, 32'd0, 32'd0, 1, 4'b0000, "R7 load code0");
        1: drive(3'd0, 32'd0, -32'sd1, 1, 4'b0000, "R7 load code1");
        2: drive(3'd0, 32'd1, 32'd0, 1, 4'b0000, "R7 load code2");
        default: drive(3'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 4'b0000, "R7 load code3");
      endcase
      for (int m = 0; m < 16; m++)
        drive(3'd7, 32'd0, 32'd0, 0, 4'(m), "R7 mask sweep");
    end

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    drive(3'd2, 32'd11, 32'd22, 1, 4'b0100, "R1 before reset");
    while (sb.size() > 0) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 sync reset result", result_o, '0);
    check("R1 sync reset code", W'(cc_o), '0);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule